// File: doc/BRIEF.md
# Serial GPIO bitstream controller

This block gives a controller many more general-purpose pins than it has package balls. It sends output levels and collects input levels over four wires: a serial clock, a data-out line, a data-in line and a load strobe. Chains of external shift registers sit on those wires. The pins are arranged as a matrix of up to 32 ports, and each port carries 1 to 4 bits. A frame walks through the enabled ports in ascending order. Within each port it walks the bits in ascending order, driving one output level and sampling one input level per serial clock period. The frame ends with a single load period, which latches the chain outputs on the far side and moves the captured input bits into readable registers.

Software configures the block through a simple register interface. A write is taken on the clock edge when the write enable is high, and a read returns data combinationally from the address. Through these registers software sets the bits per port, the clock divisor, the mask of ports that take part, and one configuration word per port. Each configuration word holds a 3-bit source code for every bit of that port. Frames are launched one at a time by a self-clearing start bit, or run back to back while auto-repeat is set.

Register map (6-bit word address): 0x00 control, 0x01 divisor, 0x02 port-enable mask, 0x08 to 0x0B captured input words, 0x20 to 0x3F per-port configuration words.

Top module: `sgpio_ctrl`

## Requirements
- R1: After reset, the control word, the port-enable mask, every port configuration word and all four input words read 0. The divisor reads 20, and the serial clock, data-out and load outputs are low.
- R2: Control bits [1:0] hold the number of bits per port minus one. During a frame, each enabled port shifts exactly that many bits plus one.
- R3: A frame visits only the ports whose bit is set in the mask at address 0x02, in ascending port order, with bits in ascending order inside each port. Configuration of disabled ports has no effect on the stream.
- R4: The configuration word of port p lives at address 0x20+p and reads back its low 12 bits. The source code for bit b sits in bits [3b+2:3b]. Code 1 drives data-out high. Code 0 and the reserved codes 2 to 7 drive it low.
- R5: Every serial period lasts D system cycles. D is the 12-bit divisor at address 0x01, with values below 2 taken as 2. The serial clock is low for the first floor(D/2) cycles of the period and high for the rest.
- R6: After the last bit of a frame, the load output is high for exactly one serial period, and data-out is low during that period.
- R7: Data-in is sampled in the last system cycle of each bit period. Input word 0x08+b, bit n, holds the value sampled for port n, bit b. The input words update at the end of the load period. Bits for disabled ports, and for bit indices beyond the width, read 0.
- R8: Writing 1 to control bit 3 launches one frame. The bit reads 1 while the frame runs and clears itself when the frame ends. While no frame runs, all three serial outputs are low.
- R9: While control bit 2 (auto-repeat) is set, each frame starts in the cycle right after the previous load period ends. When the bit is cleared, the running frame completes and the block then goes idle.
- R10: With an empty mask, a frame consists only of the load period, and all input words read 0 afterwards.
- R11: The mask, width and divisor are sampled when a frame starts. Writes made during a frame take effect from the next frame.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_we | input | 1 | Register write enable |
| reg_addr | input | 6 | Register word address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational from the address |
| sio_clk | output | 1 | Serial clock |
| sio_dout | output | 1 | Serial data to the output chain |
| sio_din | input | 1 | Serial data from the input chain |
| sio_load | output | 1 | Load strobe, one serial period per frame |

## Verification
The hardest case to reach is a register write that lands in the middle of an auto-repeat frame. The stream must keep the old mask until the boundary, and then switch with no idle cycle between frames. The bench reaches this case in two steps. It first waits for the reference model to report a completed frame. A few cycles later it rewrites the mask and the divisor, while the next frame is known to be running. The cycle-level model predicts the outputs from the frame-start snapshot, so any early or late switch shows up as a mismatch on a specific cycle.

// File: rtl/sgpio_pkg.sv
// Shared constants and types for the serial GPIO bitstream controller.
// Assumes: word-addressed register space of 64 entries, 32-bit data.
package sgpio_pkg;

    localparam int ADDR_W  = 6;
    localparam int SRC_W   = 3;

    // register word addresses
    localparam int A_CTRL     = 0;
    localparam int A_DIV      = 1;
    localparam int A_MASK     = 2;
    localparam int A_IN_BASE  = 8;
    localparam int A_CFG_BASE = 32;

    // control word bit positions
    localparam int CTL_WM1_LSB = 0;
    localparam int CTL_AUTO    = 2;
    localparam int CTL_START   = 3;

    // source code that drives a high level; every other code drives low
    localparam logic [SRC_W-1:0] SRC_HIGH = 3'd1;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_SHIFT = 2'd1,
        ST_LOAD  = 2'd2
    } seq_state_t;

    function automatic logic src_level(input logic [SRC_W-1:0] code);
        return code == SRC_HIGH;
    endfunction

endpackage

// File: rtl/sgpio_regs.sv
// Register file: control, divisor, port mask, per-port source codes and
// read mux including the captured input words.
// Assumes: MAXB is a power of two, NPORTS <= REG_W, NPORTS <= 32.
module sgpio_regs
    import sgpio_pkg::*;
#(
    parameter int NPORTS  = 32,
    parameter int MAXB    = 4,
    parameter int DIV_W   = 12,
    parameter int REG_W   = 32,
    parameter int RST_DIV = 20,
    localparam int BIT_W  = (MAXB > 1) ? $clog2(MAXB) : 1,
    localparam int CFG_W  = MAXB * SRC_W
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             we,
    input  logic [ADDR_W-1:0]                addr,
    input  logic [REG_W-1:0]                 wdata,
    output logic [REG_W-1:0]                 rdata,
    input  logic                             frame_done,
    input  logic [MAXB-1:0][NPORTS-1:0]      in_word,
    output logic [BIT_W-1:0]                 wm1,
    output logic                             auto_rep,
    output logic                             start,
    output logic [DIV_W-1:0]                 div,
    output logic [NPORTS-1:0]                mask,
    output logic [NPORTS-1:0][CFG_W-1:0]     cfg
);

    logic wr_ctrl;
    assign wr_ctrl = we && (addr == ADDR_W'(A_CTRL));

    // control, divisor and mask registers; start is set by software, cleared by frame end
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wm1      <= '0;
            auto_rep <= 1'b0;
            start    <= 1'b0;
            div      <= DIV_W'(RST_DIV);
            mask     <= '0;
        end else begin
            if (frame_done)
                start <= 1'b0;
            if (wr_ctrl) begin
                wm1      <= wdata[CTL_WM1_LSB +: BIT_W];
                auto_rep <= wdata[CTL_AUTO];
                if (wdata[CTL_START])
                    start <= 1'b1;
            end
            if (we && addr == ADDR_W'(A_DIV))
                div <= wdata[DIV_W-1:0];
            if (we && addr == ADDR_W'(A_MASK))
                mask <= wdata[NPORTS-1:0];
        end
    end

    // per-port source-code words
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg <= '0;
        end else begin
            for (int p = 0; p < NPORTS; p++)
                if (we && addr == ADDR_W'(A_CFG_BASE + p))
                    cfg[p] <= wdata[CFG_W-1:0];
        end
    end

    // combinational read mux
    always_comb begin
        rdata = '0;
        if (addr == ADDR_W'(A_CTRL)) begin
            rdata[CTL_WM1_LSB +: BIT_W] = wm1;
            rdata[CTL_AUTO]             = auto_rep;
            rdata[CTL_START]            = start;
        end
        if (addr == ADDR_W'(A_DIV))
            rdata[DIV_W-1:0] = div;
        if (addr == ADDR_W'(A_MASK))
            rdata[NPORTS-1:0] = mask;
        for (int b = 0; b < MAXB; b++)
            if (addr == ADDR_W'(A_IN_BASE + b))
                rdata[NPORTS-1:0] = in_word[b];
        for (int p = 0; p < NPORTS; p++)
            if (addr == ADDR_W'(A_CFG_BASE + p))
                rdata[CFG_W-1:0] = cfg[p];
    end

    // R8: a finished frame leaves start clear unless software sets it in the same cycle
    a_r8_start_self_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_done && !(wr_ctrl && wdata[CTL_START])) |=> !start);

endmodule

// File: rtl/sgpio_clkgen.sv
// Serial-period timer: counts system cycles within one serial period and
// derives the serial clock and the period-end pulse.
// Assumes: divisor is latched at each frame start and clamped to >= 2.
module sgpio_clkgen #(
    parameter int DIV_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             restart,
    input  logic             running,
    input  logic [DIV_W-1:0] div_in,
    output logic             pend,
    output logic             sclk
);

    logic [DIV_W-1:0] div_q;
    logic [DIV_W-1:0] ph_q;
    logic [DIV_W-1:0] div_eff;

    assign div_eff = (div_in < DIV_W'(2)) ? DIV_W'(2) : div_in;
    assign pend    = running && (ph_q == div_q - 1'b1);
    assign sclk    = running && (ph_q >= (div_q >> 1));

    // phase counter, restarted at every frame start
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            div_q <= DIV_W'(2);
            ph_q  <= '0;
        end else if (restart) begin
            div_q <= div_eff;
            ph_q  <= '0;
        end else if (running) begin
            ph_q <= pend ? '0 : ph_q + 1'b1;
        end
    end

    // R5: phase stays inside the latched period, and the period is at least two cycles
    a_r5_phase_bound: assert property (@(posedge clk) disable iff (!rst_n)
        (ph_q < div_q) && (div_q >= DIV_W'(2)));
    // R5: every new period opens with the serial clock low
    a_r5_period_starts_low: assert property (@(posedge clk) disable iff (!rst_n)
        pend |=> !sclk);

endmodule

// File: rtl/sgpio_capture.sv
// Input capture: a shadow matrix filled during the frame and a committed
// copy per bit index that software reads.
// Assumes: clear and sample never coincide; commit may coincide with clear.
module sgpio_capture #(
    parameter int NPORTS = 32,
    parameter int MAXB   = 4,
    localparam int PORT_W = $clog2(NPORTS),
    localparam int BIT_W  = (MAXB > 1) ? $clog2(MAXB) : 1
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        clear,
    input  logic                        sample,
    input  logic [PORT_W-1:0]           port,
    input  logic [BIT_W-1:0]            bidx,
    input  logic                        sdin,
    input  logic                        commit,
    output logic [MAXB-1:0][NPORTS-1:0] in_word
);

    for (genvar b = 0; b < MAXB; b++) begin : g_row
        logic [NPORTS-1:0] shadow_q;
        logic [NPORTS-1:0] word_q;

        // shadow row: zeroed at frame start, one bit written per sampled period
        always_ff @(posedge clk) begin
            if (!rst_n || clear)
                shadow_q <= '0;
            else if (sample && bidx == BIT_W'(b))
                shadow_q[port] <= sdin;
        end

        // committed row, moved over at the end of the load period
        always_ff @(posedge clk) begin
            if (!rst_n)
                word_q <= '0;
            else if (commit)
                word_q <= shadow_q;
        end

        assign in_word[b] = word_q;
    end

endmodule

// File: rtl/sgpio_seq.sv
// Frame sequencer: walks enabled ports and bits, drives data-out from the
// source codes, and issues the load period.
// Assumes: pend comes from the period timer and is only high while running.
module sgpio_seq
    import sgpio_pkg::*;
#(
    parameter int NPORTS = 32,
    parameter int MAXB   = 4,
    localparam int PORT_W = $clog2(NPORTS),
    localparam int BIT_W  = (MAXB > 1) ? $clog2(MAXB) : 1,
    localparam int CFG_W  = MAXB * SRC_W
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         go,
    input  logic                         auto_rep,
    input  logic [NPORTS-1:0]            mask,
    input  logic [BIT_W-1:0]             wm1,
    input  logic [NPORTS-1:0][CFG_W-1:0] cfg,
    input  logic                         pend,
    output logic                         frame_start,
    output logic                         frame_done,
    output logic                         sample,
    output logic                         running,
    output logic [PORT_W-1:0]            cur_port,
    output logic [BIT_W-1:0]             cur_bit,
    output logic                         sdout,
    output logic                         sload
);

    seq_state_t         st;
    logic [NPORTS-1:0]  fmask_q;
    logic [BIT_W-1:0]   fwm1_q;
    logic [PORT_W-1:0]  first_p;
    logic [PORT_W-1:0]  nxt_p;
    logic               has_nxt;
    logic [SRC_W-1:0]   code;

    assign running     = (st != ST_IDLE);
    assign frame_done  = (st == ST_LOAD) && pend;
    assign frame_start = ((st == ST_IDLE) && go) || (frame_done && auto_rep);
    assign sample      = (st == ST_SHIFT) && pend;
    assign sload       = (st == ST_LOAD);
    assign code        = cfg[cur_port][int'(cur_bit) * SRC_W +: SRC_W];
    assign sdout       = (st == ST_SHIFT) && src_level(code);

    // lowest enabled port of the live mask, for the first bit of a frame
    always_comb begin
        first_p = '0;
        for (int i = NPORTS - 1; i >= 0; i--)
            if (mask[i])
                first_p = PORT_W'(i);
    end

    // next enabled port above the current one in the frame snapshot
    always_comb begin
        nxt_p   = '0;
        has_nxt = 1'b0;
        for (int i = NPORTS - 1; i >= 0; i--)
            if (fmask_q[i] && (i > int'(cur_port))) begin
                nxt_p   = PORT_W'(i);
                has_nxt = 1'b1;
            end
    end

    // frame state, snapshot of mask and width, and the port/bit position
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st       <= ST_IDLE;
            fmask_q  <= '0;
            fwm1_q   <= '0;
            cur_port <= '0;
            cur_bit  <= '0;
        end else if (frame_start) begin
            fmask_q  <= mask;
            fwm1_q   <= wm1;
            cur_port <= first_p;
            cur_bit  <= '0;
            st       <= (mask == '0) ? ST_LOAD : ST_SHIFT;
        end else if (pend) begin
            case (st)
                ST_SHIFT: begin
                    if (cur_bit != fwm1_q) begin
                        cur_bit <= cur_bit + 1'b1;
                    end else if (has_nxt) begin
                        cur_port <= nxt_p;
                        cur_bit  <= '0;
                    end else begin
                        st <= ST_LOAD;
                    end
                end
                default: st <= ST_IDLE;
            endcase
        end
    end

    // R3: only ports from the frame snapshot are ever shifted
    a_r3_port_enabled: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_SHIFT) |-> fmask_q[cur_port]);
    // R2: bit index never passes the latched width
    a_r2_bit_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_SHIFT) |-> (cur_bit <= fwm1_q));
    // R9: with auto-repeat, the end of a load period leads straight into a new frame
    a_r9_no_gap: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_done && auto_rep) |=> running);
    // R6: data-out stays low while the load strobe is high
    a_r6_load_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        sload |-> !sdout);

endmodule

// File: rtl/sgpio_ctrl.sv
// Top of the serial GPIO bitstream controller: register file, period
// timer, frame sequencer and input capture.
// Assumes: serial-side pins are registered or retimed outside this block.
module sgpio_ctrl
    import sgpio_pkg::*;
#(
    parameter int NPORTS  = 32,
    parameter int MAXB    = 4,
    parameter int DIV_W   = 12,
    parameter int REG_W   = 32,
    parameter int RST_DIV = 20,
    localparam int PORT_W = $clog2(NPORTS),
    localparam int BIT_W  = (MAXB > 1) ? $clog2(MAXB) : 1,
    localparam int CFG_W  = MAXB * SRC_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [REG_W-1:0]  reg_wdata,
    output logic [REG_W-1:0]  reg_rdata,
    output logic              sio_clk,
    output logic              sio_dout,
    input  logic              sio_din,
    output logic              sio_load
);

    logic [BIT_W-1:0]             wm1;
    logic                         auto_rep;
    logic                         start;
    logic [DIV_W-1:0]             div;
    logic [NPORTS-1:0]            mask;
    logic [NPORTS-1:0][CFG_W-1:0] cfg;
    logic [MAXB-1:0][NPORTS-1:0]  in_word;
    logic                         frame_start;
    logic                         frame_done;
    logic                         sample;
    logic                         running;
    logic                         pend;
    logic [PORT_W-1:0]            cur_port;
    logic [BIT_W-1:0]             cur_bit;

    sgpio_regs #(
        .NPORTS(NPORTS), .MAXB(MAXB), .DIV_W(DIV_W), .REG_W(REG_W), .RST_DIV(RST_DIV)
    ) u_regs (
        .clk(clk), .rst_n(rst_n), .we(reg_we), .addr(reg_addr), .wdata(reg_wdata),
        .rdata(reg_rdata), .frame_done(frame_done), .in_word(in_word),
        .wm1(wm1), .auto_rep(auto_rep), .start(start), .div(div), .mask(mask), .cfg(cfg)
    );

    sgpio_clkgen #(.DIV_W(DIV_W)) u_clk (
        .clk(clk), .rst_n(rst_n), .restart(frame_start), .running(running),
        .div_in(div), .pend(pend), .sclk(sio_clk)
    );

    sgpio_seq #(.NPORTS(NPORTS), .MAXB(MAXB)) u_seq (
        .clk(clk), .rst_n(rst_n), .go(start | auto_rep), .auto_rep(auto_rep),
        .mask(mask), .wm1(wm1), .cfg(cfg), .pend(pend),
        .frame_start(frame_start), .frame_done(frame_done), .sample(sample),
        .running(running), .cur_port(cur_port), .cur_bit(cur_bit),
        .sdout(sio_dout), .sload(sio_load)
    );

    sgpio_capture #(.NPORTS(NPORTS), .MAXB(MAXB)) u_cap (
        .clk(clk), .rst_n(rst_n), .clear(frame_start), .sample(sample),
        .port(cur_port), .bidx(cur_bit), .sdin(sio_din), .commit(frame_done),
        .in_word(in_word)
    );

endmodule

// File: tb/sgpio_ctrl_test.sv
module sgpio_ctrl_test;

    localparam int CLK_P = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [5:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        sio_clk, sio_dout, sio_load;
    logic        sio_din = 1'b0;

    always #(CLK_P / 2) clk = ~clk;

    sgpio_ctrl uut (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .sio_clk(sio_clk),
        .sio_dout(sio_dout), .sio_din(sio_din), .sio_load(sio_load)
    );

    typedef struct {
        bit ck;
        bit sd;
        bit ld;
        bit sh;
        int port;
        int bt;
    } ent_t;

    ent_t        q[$];
    ent_t        cur;
    int          nchk = 0;
    int          nerr = 0;
    bit          chk_on = 0;
    bit          done = 0;

    // reference state
    logic [31:0] m_cfg[32];
    logic [31:0] m_mask;
    int          m_wm1, m_div, nframes;
    bit          m_auto, m_start, in_frame;
    logic [31:0] m_in[4], m_fexp[4], in_pat[4];

    function automatic ent_t idle_ent();
        ent_t e;
        e = '{ck: 0, sd: 0, ld: 0, sh: 0, port: 0, bt: 0};
        return e;
    endfunction

    // queue one frame of expected per-cycle outputs from the current snapshot
    function automatic void build_frame();
        int de;
        de = (m_div < 2) ? 2 : m_div;
        for (int b = 0; b < 4; b++) m_fexp[b] = '0;
        for (int p = 0; p < 32; p++) begin
            if (m_mask[p]) begin
                for (int b = 0; b <= m_wm1; b++) begin
                    int code;
                    code = int'((m_cfg[p] >> (3 * b)) & 32'd7);
                    for (int c = 0; c < de; c++)
                        q.push_back('{ck: (c >= de / 2), sd: (code == 1), ld: 0, sh: 1, port: p, bt: b});
                    m_fexp[b][p] = in_pat[b][p];
                end
            end
        end
        for (int c = 0; c < de; c++)
            q.push_back('{ck: (c >= de / 2), sd: 0, ld: 1, sh: 0, port: 0, bt: 0});
    endfunction

    // cycle model: decides frame starts/ends and tracks register writes
    always @(posedge clk) begin
        if (!rst_n) begin
            q.delete();
            in_frame = 0; m_auto = 0; m_start = 0; m_wm1 = 0; m_div = 20;
            m_mask = '0; nframes = 0;
            for (int p = 0; p < 32; p++) m_cfg[p] = '0;
            for (int b = 0; b < 4; b++) m_in[b] = '0;
            cur = idle_ent();
        end else begin
            if (q.size() == 0) begin
                bit go;
                go = m_start || m_auto;
                if (in_frame) begin
                    for (int b = 0; b < 4; b++) m_in[b] = m_fexp[b];
                    m_start = 0;
                    go = m_auto;
                    in_frame = 0;
                    nframes++;
                end
                if (go) begin
                    build_frame();
                    in_frame = 1;
                end
            end
            if (reg_we) begin
                case (reg_addr)
                    6'd0: begin
                        m_wm1 = int'(reg_wdata[1:0]);
                        m_auto = reg_wdata[2];
                        if (reg_wdata[3]) m_start = 1;
                    end
                    6'd1: m_div = int'(reg_wdata[11:0]);
                    6'd2: m_mask = reg_wdata;
                    default: if (reg_addr >= 6'd32) m_cfg[reg_addr - 6'd32] = reg_wdata & 32'hFFF;
                endcase
            end
            if (q.size() > 0) cur = q.pop_front();
            else cur = idle_ent();
        end
    end

    // per-cycle stream compare and data-in drive
    always @(negedge clk) begin
        if (chk_on && !done) begin
            nchk++;
            if ({sio_clk, sio_dout, sio_load} !== {cur.ck, cur.sd, cur.ld}) begin
                nerr++;
                $display("FAIL R2 R3 R4 R5 R6 R8 R9 R11 stream at %0t: got clk/dout/load=%b%b%b expected %b%b%b",
                         $time, sio_clk, sio_dout, sio_load, cur.ck, cur.sd, cur.ld);
            end
        end
        sio_din <= cur.sh ? in_pat[cur.bt][cur.port] : 1'b0;
    end

    task automatic wr(input logic [5:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(input logic [5:0] a, input logic [31:0] exp, input string tag);
        @(negedge clk);
        reg_addr = a;
        #1;
        nchk++;
        if (reg_rdata !== exp) begin
            nerr++;
            $display("FAIL %s addr=%0h: got %h expected %h", tag, a, reg_rdata, exp);
        end
    endtask

    task automatic wait_idle();
        do @(negedge clk); while (in_frame || q.size() != 0 || m_start || m_auto);
    endtask

    task automatic check_inputs(input string tag);
        for (int b = 0; b < 4; b++) rd(6'(8 + b), m_in[b], tag);
    endtask

    task automatic finish_run();
        done = 1;
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        nerr++;
        $display("FAIL R8 watchdog expired: got hung run expected completion");
        finish_run();
    end

    initial begin
        in_pat[0] = 32'hA5C3_F00F; in_pat[1] = 32'h5A3C_0FF0;
        in_pat[2] = 32'hDEAD_BEEF; in_pat[3] = 32'h1234_8765;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        chk_on = 1;

        // R1: reset values
        rd(6'd0, 32'h0, "R1 ctrl");
        rd(6'd1, 32'd20, "R1 divisor");
        rd(6'd2, 32'h0, "R1 mask");
        rd(6'd32, 32'h0, "R1 cfg0");
        rd(6'd63, 32'h0, "R1 cfg31");
        check_inputs("R1 input words");

        // R4: codes incl. reserved; disabled port 1 carries a high code (R3)
        wr(6'd32, 32'h0000_0001);          // port0: b0=1 b1=0
        wr(6'd33, 32'h0000_0249);          // port1 disabled: all 1
        wr(6'd34, 32'h0000_000A);          // port2: b0=2 b1=1
        wr(6'd36, 32'hFFFF_F00F);          // port4: b0=7 b1=1, upper bits dropped
        wr(6'd63, 32'h0000_0009);          // port31: b0=1 b1=1
        rd(6'd36, 32'h0000_000F, "R4 cfg readback");
        wr(6'd1, 32'd4);
        wr(6'd2, 32'h8000_0015);
        // R8: one-shot frame, two bits per port (R2)
        wr(6'd0, 32'h0000_0009);
        rd(6'd0, 32'h0000_0009, "R8 start reads 1 during frame");
        wait_idle();
        repeat (2) @(negedge clk);
        rd(6'd0, 32'h0000_0001, "R8 start self-cleared");
        check_inputs("R7 inputs after one-shot");

        // R5: divisor 1 clamps to 2; full mask, four bits (R2), mixed codes
        for (int p = 0; p < 32; p++) begin
            logic [31:0] w;
            w = '0;
            for (int b = 0; b < 4; b++) w[3 * b +: 3] = 3'((p + b) % 3);
            wr(6'(32 + p), w);
        end
        wr(6'd1, 32'd1);
        wr(6'd2, 32'hFFFF_FFFF);
        wr(6'd0, 32'h0000_000B);
        wait_idle();
        check_inputs("R7 inputs full mask");

        // R7: one bit per port, odd divisor, sparse mask
        wr(6'd1, 32'd5);
        wr(6'd2, 32'h0101_8002);
        wr(6'd0, 32'h0000_0008);
        wait_idle();
        check_inputs("R7 inputs width one");
        rd(6'd9, 32'h0, "R7 bit index beyond width");

        // R10: empty mask gives a load-only frame and clears the inputs
        wr(6'd2, 32'h0);
        wr(6'd0, 32'h0000_0008);
        wait_idle();
        rd(6'd8, 32'h0, "R10 input word 0 after empty frame");
        check_inputs("R10 inputs");

        // R9 auto-repeat; R11 mid-frame writes apply from the next frame
        wr(6'd1, 32'd3);
        wr(6'd2, 32'h0000_0006);
        wr(6'd0, 32'h0000_0004);
        begin
            int f0;
            f0 = nframes;
            while (nframes == f0) @(negedge clk);
            repeat (2) @(negedge clk);
            wr(6'd2, 32'h0000_0001);
            wr(6'd1, 32'd2);
            f0 = nframes;
            while (nframes < f0 + 2) @(negedge clk);
        end
        wr(6'd0, 32'h0000_0000);
        wait_idle();
        check_inputs("R9 R11 inputs after auto-repeat");
        repeat (5) @(negedge clk);
        finish_run();
    end

endmodule